// File: doc/BRIEF.md
# Command Slot Issue Tracker

This block keeps the command-slot bookkeeping for one storage port of a host bus adapter. Software starts a command by writing a 1 to that slot's bit in an issue register. The tracker selects the next pending slot and offers its index to a downstream command fetch engine through a valid/ready handshake. It then waits for that engine to report either success or a task-file error.

On success, the slot's issue bit clears in hardware and a command-done status bit rises. On error, a task-file-error status bit rises, the slot stays issued, and further dispatch is held until software clears the error bit. A queued-active mask shares the register port with the other registers. A free-slot finder reports the lowest slot that is clear in both masks. An interrupt line combines the status bits with their enables.

All registers are reached through a small synchronous read/write port. Read data is registered.

Top module: `cmd_slot_tracker`

## Requirements
- R1: After reset, the issue, active, status and enable registers read 0, and `disp_valid` and `irq` are 0. The capability register (address 0) reads `NUM_SLOTS-1` in bits [4:0], with all other bits 0. `reg_rdata` shows the register selected by `reg_addr` one clock after the address is presented.
- R2: Writing address 1 (issue) sets every issue bit whose write-data bit is 1. Write-data bits that are 0, and bits at or above `NUM_SLOTS`, leave the register unchanged, so software can never clear an issue bit.
- R3: With no command outstanding and the task-file-error bit clear, the lowest-index issued slot is offered on `disp_slot` with `disp_valid` high. The offer holds until `disp_ready`. No new offer appears until the accepted command ends.
- R4: A `done_ok` pulse while a command is outstanding clears that slot's issue bit and sets status bit 0 (command done).
- R5: A `done_err` pulse while a command is outstanding sets status bit 1 (task-file error) and leaves the slot's issue bit set. No slot is offered while status bit 1 is set. After it is cleared, the lowest issued slot is offered again.
- R6: Status (address 3) is write-1-to-clear. A 1 in write data clears the matching bit, a 0 leaves it, and writing all ones clears both bits.
- R7: The active register (address 2) is set by writing 1s, ignores written 0s, and clears bit n when input `act_clr[n]` is high for a cycle.
- R8: The free register (address 5) reads the lowest slot index whose bit is clear in both issue and active in bits [4:0], with bit 31 = 0. When no slot is free it reads bit 31 = 1 and index 0.
- R9: `irq` is high exactly when some status bit and the matching enable bit (address 4, bits [1:0]) are both set. It updates one clock after the status or enable registers change.
- R10: `done_ok` and `done_err` have no effect unless a command has been accepted and is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 cap, 1 issue, 2 active, 3 status, 4 enable, 5 free) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| act_clr | input | NUM_SLOTS | Hardware clear of active-mask bits |
| disp_valid | output | 1 | Slot offer to fetch engine |
| disp_slot | output | SLOT_W | Offered / outstanding slot index |
| disp_ready | input | 1 | Fetch engine accepts the offer |
| done_ok | input | 1 | Outstanding command finished successfully |
| done_err | input | 1 | Outstanding command hit a task-file error |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a stalled error: one slot has failed, other slots are still issued behind it, and dispatch must stay frozen until software acknowledges the error. The stimulus reaches it by accepting the lowest slot of a multi-slot pattern and returning an error. It then confirms that no offer appears and that the issue mask is intact, clears the error bit, and checks that the same slot is offered again. The free-slot finder is also hard to sweep, because software cannot clear issue bits. Each issue/active combination is therefore built from reset with the engine never accepting, so that the issue mask stays exactly as written.

// File: rtl/slot_trk_pkg.sv
package slot_trk_pkg;
  typedef enum logic [2:0] {
    A_CAP    = 3'd0,
    A_ISSUE  = 3'd1,
    A_ACTIVE = 3'd2,
    A_STATUS = 3'd3,
    A_ENABLE = 3'd4,
    A_FREE   = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    D_IDLE,
    D_OFFER,
    D_BUSY
  } disp_state_e;

  localparam int ST_DONE = 0;
  localparam int ST_TFE  = 1;
  localparam int ST_W    = 2;
endpackage

// File: rtl/slot_lowest.sv
module slot_lowest #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/slot_dispatch.sv
module slot_dispatch
  import slot_trk_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend,
  input  logic          halt,
  input  logic          disp_ready,
  input  logic          done_ok,
  input  logic          done_err,
  output logic          disp_valid,
  output logic [IW-1:0] disp_slot,
  output logic          ok_pulse,
  output logic          err_pulse,
  output logic [N-1:0]  clr_mask
);
  disp_state_e   state_q;
  logic [IW-1:0] pick_idx;
  logic          pick_any;

  slot_lowest #(.N(N), .IW(IW)) u_pick (
    .vec (pend),
    .idx (pick_idx),
    .any (pick_any)
  );

  assign ok_pulse  = (state_q == D_BUSY) && done_ok;
  assign err_pulse = (state_q == D_BUSY) && done_err && !done_ok;
  assign clr_mask  = ok_pulse ? (N'(1) << disp_slot) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= D_IDLE;
      disp_valid <= 1'b0;
      disp_slot  <= '0;
    end else begin
      case (state_q)
        D_IDLE: if (pick_any && !halt) begin
          state_q    <= D_OFFER;
          disp_valid <= 1'b1;
          disp_slot  <= pick_idx;
        end
        D_OFFER: if (disp_ready) begin
          state_q    <= D_BUSY;
          disp_valid <= 1'b0;
        end
        D_BUSY: if (done_ok || done_err) state_q <= D_IDLE;
        default: state_q <= D_IDLE;
      endcase
    end
  end

  // R3: an offer is held unchanged until accepted
  p_hold_offer_r3: assert property (@(posedge clk) disable iff (rst)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_slot));
endmodule

// File: rtl/cmd_slot_tracker.sv
module cmd_slot_tracker
  import slot_trk_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_SLOTS-1:0] act_clr,
  output logic                 disp_valid,
  output logic [SLOT_W-1:0]    disp_slot,
  input  logic                 disp_ready,
  input  logic                 done_ok,
  input  logic                 done_err,
  output logic                 irq
);
  localparam int N = NUM_SLOTS;
  localparam logic [4:0] CAP_NS = 5'(N - 1);

  logic [N-1:0]    issue_q, act_q, clr_mask, wmask, free_vec, low_below;
  logic [ST_W-1:0] ists_q, ie_q;
  logic            ok_pulse, err_pulse, free_any;
  logic [SLOT_W-1:0] free_idx;
  logic            wr_iss, wr_act, wr_st, wr_ie;

  assign wmask  = reg_wdata[N-1:0];
  assign wr_iss = reg_we && (reg_addr == A_ISSUE);
  assign wr_act = reg_we && (reg_addr == A_ACTIVE);
  assign wr_st  = reg_we && (reg_addr == A_STATUS);
  assign wr_ie  = reg_we && (reg_addr == A_ENABLE);

  slot_dispatch #(.N(N), .IW(SLOT_W)) u_disp (
    .clk        (clk),
    .rst        (rst),
    .pend       (issue_q),
    .halt       (ists_q[ST_TFE]),
    .disp_ready (disp_ready),
    .done_ok    (done_ok),
    .done_err   (done_err),
    .disp_valid (disp_valid),
    .disp_slot  (disp_slot),
    .ok_pulse   (ok_pulse),
    .err_pulse  (err_pulse),
    .clr_mask   (clr_mask)
  );

  assign free_vec = ~(issue_q | act_q);

  slot_lowest #(.N(N), .IW(SLOT_W)) u_free (
    .vec (free_vec),
    .idx (free_idx),
    .any (free_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_q   <= '0;
      act_q     <= '0;
      ists_q    <= '0;
      ie_q      <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      issue_q <= (issue_q & ~clr_mask) | (wr_iss ? wmask : '0);
      act_q   <= (act_q & ~act_clr) | (wr_act ? wmask : '0);
      ists_q  <= (ists_q & ~(wr_st ? reg_wdata[ST_W-1:0] : '0))
               | {err_pulse, ok_pulse};
      if (wr_ie) ie_q <= reg_wdata[ST_W-1:0];
      irq <= |(ists_q & ie_q);
      case (reg_addr)
        A_CAP:    reg_rdata <= 32'(CAP_NS);
        A_ISSUE:  reg_rdata <= 32'(issue_q);
        A_ACTIVE: reg_rdata <= 32'(act_q);
        A_STATUS: reg_rdata <= 32'(ists_q);
        A_ENABLE: reg_rdata <= 32'(ie_q);
        A_FREE:   reg_rdata <= free_any ? 32'(free_idx) : 32'h8000_0000;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign low_below = (N'(1) << disp_slot) - N'(1);

  // R3: a fresh offer names an issued slot with no lower issued slot
  p_offer_lowest_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(disp_valid) |-> (($past(issue_q) & low_below) == '0) && issue_q[disp_slot]);

  // R4: success clears the outstanding slot's issue bit
  p_ok_clears_r4: assert property (@(posedge clk) disable iff (rst)
    ok_pulse && !(wr_iss && reg_wdata[disp_slot]) |=> !issue_q[$past(disp_slot)] && ists_q[ST_DONE]);

  // R5: error keeps the issue bit and flags the status
  p_err_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> issue_q[$past(disp_slot)] && ists_q[ST_TFE]);

  // R5: no offer starts while the error flag is pending
  p_halt_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(disp_valid) |-> !$past(ists_q[ST_TFE]));
endmodule

// File: tb/sim_cmd_slot_tracker.sv
module sim_cmd_slot_tracker;
  localparam int N = 4;
  localparam int W = 2;

  logic clk = 1'b0, rst = 1'b1, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] act_clr = '0;
  logic disp_valid, disp_ready = 1'b0, done_ok = 1'b0, done_err = 1'b0, irq;
  logic [W-1:0] disp_slot;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cmd_slot_tracker #(.NUM_SLOTS(N)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .act_clr(act_clr),
    .disp_valid(disp_valid), .disp_slot(disp_slot), .disp_ready(disp_ready),
    .done_ok(done_ok), .done_err(done_err), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk) begin reg_we = 1'b1; reg_addr = a; reg_wdata = d; end
    @(negedge clk) reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk) reg_addr = a;
    @(negedge clk) d = reg_rdata;
  endtask

  function automatic int lowest(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) lowest = i;
    if (v == 0) lowest = 0;
  endfunction

  task automatic wait_offer(input string tag);
    int n = 0;
    while (!disp_valid && n < 20) begin @(negedge clk); n++; end
    chk(tag, {31'b0, disp_valid}, 32'd1);
  endtask

  task automatic accept();
    @(negedge clk) disp_ready = 1'b1;
    @(negedge clk) disp_ready = 1'b0;
  endtask

  task automatic pulse_done(input logic ok);
    @(negedge clk) begin done_ok = ok; done_err = !ok; end
    @(negedge clk) begin done_ok = 1'b0; done_err = 1'b0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, rem, exp;
    do_reset();
    // R1 reset state and capability
    rd(3'd0, d); chk("R1 cap", d, 32'd3);
    rd(3'd1, d); chk("R1 issue", d, 0);
    rd(3'd2, d); chk("R1 active", d, 0);
    rd(3'd3, d); chk("R1 status", d, 0);
    rd(3'd4, d); chk("R1 enable", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 disp_valid", {31'b0, disp_valid}, 0);

    // R8 exhaustive free-finder sweep
    for (int iss = 0; iss < 16; iss++) begin
      for (int act = 0; act < 16; act++) begin
        do_reset();
        wr(3'd1, iss);
        wr(3'd2, act);
        rd(3'd5, d);
        rem = ~(iss | act) & 32'hF;
        exp = (rem == 0) ? 32'h8000_0000 : lowest(rem);
        chk($sformatf("R8 free iss=%0h act=%0h", iss, act), d, exp);
      end
    end

    // R2 writes of 0 and out-of-range bits are ignored
    do_reset();
    wr(3'd1, 32'h5); rd(3'd1, d); chk("R2 set", d, 32'h5);
    wr(3'd1, 32'h0); rd(3'd1, d); chk("R2 zero write", d, 32'h5);
    wr(3'd1, 32'hF0); rd(3'd1, d); chk("R2 high bits", d, 32'h5);
    wr(3'd1, 32'h2); rd(3'd1, d); chk("R2 or-set", d, 32'h7);

    // R3/R4 dispatch order sweep over every pattern
    for (int p = 1; p < 16; p++) begin
      do_reset();
      wr(3'd1, p);
      rem = p;
      while (rem != 0) begin
        wait_offer("R3 offer");
        chk($sformatf("R3 order p=%0h", p), disp_slot, lowest(rem));
        exp = lowest(rem);
        accept();
        repeat (3) @(negedge clk);
        chk("R3 single outstanding", {31'b0, disp_valid}, 0);
        pulse_done(1'b1);
        rem = rem & ~(32'd1 << exp);
        rd(3'd1, d); chk($sformatf("R4 clear p=%0h", p), d, rem);
      end
      rd(3'd3, d); chk("R4 done bit", d, 32'h1);
      chk("R9 irq masked", {31'b0, irq}, 0);
      wr(3'd4, 32'h1);
      @(negedge clk);
      chk("R9 irq enabled", {31'b0, irq}, 1);
    end

    // R10 done strobes without an accepted command
    do_reset();
    wr(3'd1, 32'h1);
    wait_offer("R10 offer");
    pulse_done(1'b1);
    pulse_done(1'b0);
    rd(3'd1, d); chk("R10 issue kept", d, 32'h1);
    rd(3'd3, d); chk("R10 status clean", d, 0);
    chk("R10 offer kept", {31'b0, disp_valid}, 1);

    // R5 error stalls dispatch and keeps issue bit
    do_reset();
    wr(3'd4, 32'h2);
    wr(3'd1, 32'h6);
    wait_offer("R5 offer");
    chk("R5 slot", disp_slot, 1);
    accept();
    pulse_done(1'b0);
    rd(3'd3, d); chk("R5 tfe bit", d, 32'h2);
    rd(3'd1, d); chk("R5 issue kept", d, 32'h6);
    repeat (5) @(negedge clk);
    chk("R5 halted", {31'b0, disp_valid}, 0);
    chk("R9 irq on error", {31'b0, irq}, 1);
    // R6 write of 0 keeps, 1 clears
    wr(3'd3, 32'h0); rd(3'd3, d); chk("R6 zero keeps", d, 32'h2);
    wr(3'd3, 32'h2); rd(3'd3, d); chk("R6 w1c", d, 0);
    @(negedge clk);
    chk("R9 irq drops", {31'b0, irq}, 0);
    wait_offer("R5 resume");
    chk("R5 resume slot", disp_slot, 1);
    accept();
    pulse_done(1'b0);
    rd(3'd3, d); chk("R6 set again", d, 32'h2);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); chk("R6 all ones", d, 0);

    // R7 active mask
    do_reset();
    wr(3'd2, 32'hA); rd(3'd2, d); chk("R7 set", d, 32'hA);
    wr(3'd2, 32'h0); rd(3'd2, d); chk("R7 zero write", d, 32'hA);
    @(negedge clk) act_clr = 4'h8;
    @(negedge clk) act_clr = 4'h0;
    rd(3'd2, d); chk("R7 hw clear", d, 32'h2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule